// File: doc/BRIEF.md
# GPIO Pin Ownership Controller

This block sits between a 32-pin pad ring and the logic that wants to use those pads. For every pin it decides who owns the pad. The owner is either the block's own general-purpose register set or one of four alternate peripheral functions. From that decision it drives the pad output level and the pad output enable. An open-drain option works the same way whichever owner is active: a high level releases the pad, and only a low level is actively driven.

Software reaches the block through a simple register bus. The bus has a write strobe, a word address, write data, and read data that follows the address without a clock. The output value register can be written whole, or changed through a set-only alias or a clear-only alias. All three forms update on the clock edge that samples the write.

The raw pad levels pass through a two-stage synchronizer. The synchronized copy goes, ungated, to the peripherals. It also appears in a readable level register, where a pin's bit shows only if the register set owns that pin or the pin's interrupt enable input is set.

Top module: `gpio_owner_ctrl`

## Requirements
- R1: After reset every pin is register-owned and all output enables, open-drain enables and output values are 0. Reading the ownership register (address 0) then returns all ones, and the enable register (address 3) returns 0.
- R2: Ownership register (address 0): a bit of 1 gives the pin to the register set, and a bit of 0 gives it to a peripheral function.
- R3: For a peripheral-owned pin i, the function index is {select-high[i], select-low[i]}, taken from address 2 and address 1. Index 0 picks function A (fn_out[0], fn_oe[0]) and index 3 picks function D (fn_out[3], fn_oe[3]).
- R4: For a peripheral-owned pin without open-drain, pad_out and pad_oe follow the selected function's output and output-enable bits.
- R5: For a register-owned pin without open-drain, pad_oe equals the enable register bit (address 3) and pad_out equals the output value register bit.
- R6: The output value register is written whole at address 4. At address 5, written 1 bits are set. At address 6, written 1 bits are cleared. Each of the three updates the register, and pad_out, in the cycle after the bus write. Reads of addresses 4, 5 and 6 return the value register.
- R7: When the open-drain enable bit (address 7) is 1, for either owner: pad_out is 0, and pad_oe is 1 only when the owner enables the output and drives a low level.
- R8: The level register (address 8) shows the pad level two clock cycles after a pad change.
- R9: A level register bit reads as the synchronized pad level only when the pin is register-owned or its irq_en bit is 1. Otherwise it reads as 0.
- R10: Writes to address 8 or to an unmapped address change no register, and reads of an unmapped address return 0.
- R11: fn_in carries the synchronized pad levels to the peripherals for every pin, regardless of ownership or interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| fn_out | input | 4x32 | Output level of each peripheral function, index 0 = A |
| fn_oe | input | 4x32 | Output enable of each peripheral function |
| irq_en | input | 32 | Per-pin interrupt enable, used only to gate level reads |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output level |
| pad_oe | output | 32 | Pad output enable |
| fn_in | output | 32 | Synchronized pad levels for the peripherals |

## Verification
The hardest case to reach is a pin that is peripheral-owned and in open-drain mode, with the selected function mixing high and low levels and enabled and disabled outputs. Only there do owner selection, function selection and open-drain gating act on the same bit together. The stimulus gives each function a distinct bit pattern on fn_out and fn_oe. It sets the select registers so that pin i uses function i mod 4, then enables open-drain on all pins. A pin-by-pin model in the bench then predicts every pad bit. The level register's gating needs ownership and irq_en both toggled while a fixed pattern sits on the pads. That pattern is given time to cross the synchronizer before each read.

// File: rtl/gpio_own_pkg.sv
package gpio_own_pkg;
  localparam int ADDR_W = 4;
  localparam int NFUNC  = 4;
  localparam int SEL_W  = $clog2(NFUNC);

  typedef enum logic [ADDR_W-1:0] {
    A_OWN   = 4'd0,
    A_SEL0  = 4'd1,
    A_SEL1  = 4'd2,
    A_OE    = 4'd3,
    A_VAL   = 4'd4,
    A_VSET  = 4'd5,
    A_VCLR  = 4'd6,
    A_ODEN  = 4'd7,
    A_LEVEL = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_own_sync.sv
module gpio_own_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= din;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_own_regs.sv
module gpio_own_regs
  import gpio_own_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  lvl_sync,
  input  logic [NPINS-1:0]  irq_en,
  output logic [NPINS-1:0]  rdata,
  output logic [NPINS-1:0]  own_q,
  output logic [NPINS-1:0]  sel0_q,
  output logic [NPINS-1:0]  sel1_q,
  output logic [NPINS-1:0]  oe_q,
  output logic [NPINS-1:0]  val_q,
  output logic [NPINS-1:0]  od_q
);
  logic [NPINS-1:0] own_d, sel0_d, sel1_d, oe_d, val_d, od_d;

  // next-state
  always_comb begin
    own_d  = own_q;
    sel0_d = sel0_q;
    sel1_d = sel1_q;
    oe_d   = oe_q;
    val_d  = val_q;
    od_d   = od_q;
    case (reg_addr_e'(addr))
      A_OWN:  own_d  = wdata;
      A_SEL0: sel0_d = wdata;
      A_SEL1: sel1_d = wdata;
      A_OE:   oe_d   = wdata;
      A_VAL:  val_d  = wdata;
      A_VSET: val_d  = val_q | wdata;
      A_VCLR: val_d  = val_q & ~wdata;
      A_ODEN: od_d   = wdata;
      default: ;
    endcase
  end

  // state, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '1;
      sel0_q <= '0;
      sel1_q <= '0;
      oe_q   <= '0;
      val_q  <= '0;
      od_q   <= '0;
    end else if (wr) begin
      own_q  <= own_d;
      sel0_q <= sel0_d;
      sel1_q <= sel1_d;
      oe_q   <= oe_d;
      val_q  <= val_d;
      od_q   <= od_d;
    end
  end

  // read path
  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      A_OWN:                rdata = own_q;
      A_SEL0:               rdata = sel0_q;
      A_SEL1:               rdata = sel1_q;
      A_OE:                 rdata = oe_q;
      A_VAL, A_VSET, A_VCLR: rdata = val_q;
      A_ODEN:               rdata = od_q;
      A_LEVEL:              rdata = lvl_sync & (own_q | irq_en);
      default:              rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_own_pinmux.sv
module gpio_own_pinmux
  import gpio_own_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0]            own,
  input  logic [NPINS-1:0]            sel0,
  input  logic [NPINS-1:0]            sel1,
  input  logic [NPINS-1:0]            oe,
  input  logic [NPINS-1:0]            val,
  input  logic [NPINS-1:0]            od,
  input  logic [NFUNC-1:0][NPINS-1:0] fn_out,
  input  logic [NFUNC-1:0][NPINS-1:0] fn_oe,
  output logic [NPINS-1:0]            pad_out,
  output logic [NPINS-1:0]            pad_oe
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [SEL_W-1:0] fsel;
    logic             drv_val;
    logic             drv_en;

    assign fsel    = {sel1[g], sel0[g]};
    assign drv_val = own[g] ? val[g] : fn_out[fsel][g];
    assign drv_en  = own[g] ? oe[g]  : fn_oe[fsel][g];
    // open-drain: high releases the pad, only low is driven
    assign pad_out[g] = drv_val & ~od[g];
    assign pad_oe[g]  = drv_en & ~(od[g] & drv_val);
  end
endmodule

// File: rtl/gpio_owner_ctrl.sv
module gpio_owner_ctrl
  import gpio_own_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [NPINS-1:0]            bus_wdata,
  output logic [NPINS-1:0]            bus_rdata,
  input  logic [NFUNC-1:0][NPINS-1:0] fn_out,
  input  logic [NFUNC-1:0][NPINS-1:0] fn_oe,
  input  logic [NPINS-1:0]            irq_en,
  input  logic [NPINS-1:0]            pad_in,
  output logic [NPINS-1:0]            pad_out,
  output logic [NPINS-1:0]            pad_oe,
  output logic [NPINS-1:0]            fn_in
);
  localparam int SYNC_STAGES = 2;

  logic [NPINS-1:0] own_q, sel0_q, sel1_q, oe_q, val_q, od_q, lvl_sync;

  gpio_own_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(lvl_sync)
  );

  gpio_own_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .lvl_sync(lvl_sync), .irq_en(irq_en),
    .rdata(bus_rdata), .own_q(own_q), .sel0_q(sel0_q), .sel1_q(sel1_q),
    .oe_q(oe_q), .val_q(val_q), .od_q(od_q)
  );

  gpio_own_pinmux #(.NPINS(NPINS)) u_mux (
    .own(own_q), .sel0(sel0_q), .sel1(sel1_q), .oe(oe_q), .val(val_q),
    .od(od_q), .fn_out(fn_out), .fn_oe(fn_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign fn_in = lvl_sync;
endmodule

// File: rtl/gpio_owner_ctrl_chk.sv
module gpio_owner_ctrl_chk
  import gpio_own_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  irq_en,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  fn_in,
  input logic [NPINS-1:0]  own_q,
  input logic [NPINS-1:0]  oe_q,
  input logic [NPINS-1:0]  val_q,
  input logic [NPINS-1:0]  od_q
);
  logic [1:0] up_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  p_vset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_VSET) |=> ((val_q & $past(bus_wdata)) == $past(bus_wdata)));

  p_vclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_VCLR) |=> ((val_q & $past(bus_wdata)) == '0));

  p_od_no_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (od_q & pad_out) == '0);

  p_reg_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ oe_q) & own_q & ~od_q) == '0);

  p_level_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_LEVEL) |-> ((bus_rdata & ~(own_q | irq_en)) == '0));

  p_sync_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 2'd2) |-> (fn_in == $past(pad_in, 2)));
endmodule

bind gpio_owner_ctrl gpio_owner_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en(irq_en),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .fn_in(fn_in),
  .own_q(own_q), .oe_q(oe_q), .val_q(val_q), .od_q(od_q)
);

// File: tb/gpio_owner_ctrl_tb_top.sv
module gpio_owner_ctrl_tb_top;
  import gpio_own_pkg::*;

  localparam int N = 32;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    bus_wr = 1'b0;
  logic [ADDR_W-1:0]       bus_addr = '0;
  logic [N-1:0]            bus_wdata = '0;
  logic [N-1:0]            bus_rdata;
  logic [NFUNC-1:0][N-1:0] fn_out = '0;
  logic [NFUNC-1:0][N-1:0] fn_oe = '0;
  logic [N-1:0]            irq_en = '0;
  logic [N-1:0]            pad_in = '0;
  logic [N-1:0]            pad_out, pad_oe, fn_in;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  gpio_owner_ctrl #(.NPINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fn_out(fn_out),
    .fn_oe(fn_oe), .irq_en(irq_en), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .fn_in(fn_in)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [N-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_out", pad_out, '0);
    rd(A_OWN, d); check("R1 own", d, '1);
    rd(A_OE, d);  check("R1 oe", d, '0);
  endtask

  task automatic t_reg_drive();
    wr(A_OWN, '1);
    wr(A_OE, 32'h0000FFFF);
    wr(A_VAL, 32'h12345678);
    #1;
    check("R5 pad_oe", pad_oe, 32'h0000FFFF);
    check("R5 pad_out", pad_out, 32'h12345678);
  endtask

  task automatic t_set_clr();
    logic [N-1:0] d;
    wr(A_VAL, 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_VSET; bus_wdata = 32'h000000F0;
    #1; check("R6 set not before edge", pad_out, 32'h0);
    @(negedge clk); bus_wr = 1'b0;
    #1; check("R6 set after edge", pad_out, 32'h000000F0);
    wr(A_VCLR, 32'h00000030);
    #1; check("R6 clear", pad_out, 32'h000000C0);
    rd(A_VSET, d); check("R6 alias read", d, 32'h000000C0);
  endtask

  task automatic t_periph();
    logic [N-1:0] eo, ee;
    fn_out[0] = 32'h0000FFFF; fn_out[1] = 32'h00FF00FF;
    fn_out[2] = 32'h0F0F0F0F; fn_out[3] = 32'h33333333;
    fn_oe[0]  = 32'hFFFFFFFF; fn_oe[1]  = 32'h55555555;
    fn_oe[2]  = 32'hAAAAAAAA; fn_oe[3]  = 32'h0F00F00F;
    wr(A_ODEN, '0);
    wr(A_SEL0, 32'hAAAAAAAA);
    wr(A_SEL1, 32'hCCCCCCCC);
    wr(A_OWN, '0);
    for (int i = 0; i < N; i++) begin
      eo[i] = fn_out[i % 4][i];
      ee[i] = fn_oe[i % 4][i];
    end
    #1;
    check("R3/R4 mixed select out", pad_out, eo);
    check("R4 mixed select oe", pad_oe, ee);
    wr(A_SEL0, '1); wr(A_SEL1, '1);
    #1; check("R3 all D out", pad_out, fn_out[3]);
    wr(A_SEL0, '0); wr(A_SEL1, '0);
    #1; check("R3 all A oe", pad_oe, fn_oe[0]);
    wr(A_OWN, 32'hFFFF0000);
    wr(A_VAL, 32'h5A5A0000);
    #1; check("R2 split ownership", pad_out, {16'h5A5A, fn_out[0][15:0]});
  endtask

  task automatic t_od();
    logic [N-1:0] eo, ee;
    wr(A_OWN, '1); wr(A_OE, '1); wr(A_VAL, 32'h0F0F0F0F);
    wr(A_ODEN, '1);
    #1;
    check("R7 reg-owned od oe", pad_oe, 32'hF0F0F0F0);
    check("R7 reg-owned od out", pad_out, '0);
    wr(A_SEL0, 32'hAAAAAAAA); wr(A_SEL1, 32'hCCCCCCCC);
    wr(A_OWN, '0);
    for (int i = 0; i < N; i++) ee[i] = fn_oe[i % 4][i] & ~fn_out[i % 4][i];
    eo = '0;
    #1;
    check("R7 periph-owned od oe", pad_oe, ee);
    check("R7 periph-owned od out", pad_out, eo);
    wr(A_ODEN, '0);
  endtask

  task automatic t_level();
    logic [N-1:0] d;
    wr(A_OWN, '1);
    irq_en = '0;
    @(negedge clk); pad_in = 32'hDEADBEEF;
    @(negedge clk); rd(A_LEVEL, d); check("R8 one cycle lag old", d, 32'h0);
    @(negedge clk); rd(A_LEVEL, d); check("R8 two cycle new", d, 32'hDEADBEEF);
    wr(A_OWN, 32'h0000FFFF); irq_en = 32'h00FF0000;
    rd(A_LEVEL, d); check("R9 gated level", d, 32'h00ADBEEF);
    wr(A_OWN, '0); irq_en = '0;
    rd(A_LEVEL, d); check("R9 fully gated", d, 32'h0);
    check("R11 fn_in ungated", fn_in, 32'hDEADBEEF);
  endtask

  task automatic t_ignored();
    logic [N-1:0] d;
    wr(A_OWN, '1);
    wr(A_OE, 32'h00C0FFEE);
    wr(A_LEVEL, '0);
    rd(A_LEVEL, d); check("R10 level write ignored", d, 32'hDEADBEEF);
    wr(4'd15, '1);
    rd(A_OE, d); check("R10 unmapped write ignored", d, 32'h00C0FFEE);
    rd(4'd15, d); check("R10 unmapped read zero", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg_drive();
    t_set_clr();
    t_periph();
    t_od();
    t_level();
    t_ignored();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule